// File: doc/BRIEF.md
# Size-Tagged Pointer Decoder

This block decodes a pointer that carries its operand size inside itself. The position of the highest set bit splits the pointer into two parts. The zero bits above it give the size exponent N, so the operand spans 2**N bytes. The bits below it, moved up by N places, give a byte address that is always naturally aligned. A 10-bit pointer therefore reaches the same 9-bit byte space as a plain address while also telling the datapath how wide the access is. The hardware is a leading-zero count followed by a left shift.

The outputs are the size exponent, a byte count, the aligned byte address and a valid flag. Two classification flags split the valid pointers into two groups. Sizes of one to eight bytes are marked as transferable. Larger encodings, up to the pointer that names the whole memory as one block, decode fully but are marked as oversize. A parameter selects plain combinational outputs or one register stage.

Top module: `tagged_ptr_decode`

## Requirements
- R1: `size_exp` equals the number of zero bits above the highest set bit of `ptr`.
- R2: `byte_addr` equals the bits of `ptr` below its highest set bit, shifted left by `size_exp`, with zeros filled in at the bottom.
- R3: For every valid pointer, the lowest `size_exp` bits of `byte_addr` are zero.
- R4: A pointer with only bit 0 set decodes to `size_exp` = PTR_W-1, `byte_addr` = 0, `byte_cnt` = 2**(PTR_W-1), and is flagged oversize.
- R5: `byte_cnt` equals 1 shifted left by `size_exp` whenever `valid` is high.
- R6: The all-zero pointer drives `valid`, `size_exp`, `byte_cnt`, `byte_addr`, `fits` and `oversize` all to zero.
- R7: For a valid pointer, `fits` is high exactly when `size_exp` is at most FIT_MAX_EXP (default 3), and `oversize` is high exactly when it is larger. Both are low when `valid` is low.
- R8: With OUT_REG = 0 the outputs follow `ptr` in the same cycle. With OUT_REG = 1 they show the decode of `ptr` sampled at the previous rising edge of `clk`, and they are all zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| ptr | input | PTR_W | Size-tagged pointer |
| valid | output | 1 | Pointer has at least one set bit |
| size_exp | output | $clog2(PTR_W) | Size exponent N |
| byte_cnt | output | PTR_W | Operand size in bytes, 2**N |
| byte_addr | output | PTR_W-1 | Aligned byte address |
| fits | output | 1 | Size is within the transferable range |
| oversize | output | 1 | Valid pointer whose size is beyond the transferable range |

## Verification
The bench builds two copies of the decoder with the default width of 10 and the default transfer limit of 3. One copy has OUT_REG = 0 and the other has OUT_REG = 1. The first copy lets all 1024 pointer values be compared in the same cycle, including the null pointer, the whole-memory pointer and both sides of the 8-byte limit. The second copy brings the reset state and the one-cycle latency within reach. The check that its outputs still hold the previous decode just before the edge catches a missing register or a register bypass.

// File: rtl/tagged_ptr_decode.sv
module tagged_ptr_decode #(
  parameter int PTR_W = 10,
  parameter int FIT_MAX_EXP = 3,
  parameter bit OUT_REG = 1'b1,
  localparam int ADDR_W = PTR_W - 1,
  localparam int EXP_W = $clog2(PTR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  ptr,
  output logic              valid,
  output logic [EXP_W-1:0]  size_exp,
  output logic [PTR_W-1:0]  byte_cnt,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              fits,
  output logic              oversize
);

  logic             hit;
  logic [EXP_W-1:0] msb;
  logic [EXP_W-1:0] lz;

  always_comb begin
    hit = 1'b0;
    msb = '0;
    for (int i = 0; i < PTR_W; i++) begin
      if (ptr[i]) begin
        hit = 1'b1;
        msb = EXP_W'(i);
      end
    end
  end

  assign lz = EXP_W'(PTR_W - 1) - msb;

  logic              d_valid, d_fits, d_over;
  logic [EXP_W-1:0]  d_exp;
  logic [PTR_W-1:0]  d_cnt;
  logic [ADDR_W-1:0] d_addr;

  assign d_valid = hit;
  assign d_exp   = hit ? lz : '0;
  assign d_cnt   = hit ? (PTR_W'(1) << lz) : '0;
  assign d_addr  = hit ? ADDR_W'(ptr << lz) : '0;
  assign d_fits  = hit && (lz <= EXP_W'(FIT_MAX_EXP));
  assign d_over  = hit && !d_fits;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid     <= 1'b0;
          size_exp  <= '0;
          byte_cnt  <= '0;
          byte_addr <= '0;
          fits      <= 1'b0;
          oversize  <= 1'b0;
        end else begin
          valid     <= d_valid;
          size_exp  <= d_exp;
          byte_cnt  <= d_cnt;
          byte_addr <= d_addr;
          fits      <= d_fits;
          oversize  <= d_over;
        end
      end
    end else begin : g_comb
      assign valid     = d_valid;
      assign size_exp  = d_exp;
      assign byte_cnt  = d_cnt;
      assign byte_addr = d_addr;
      assign fits      = d_fits;
      assign oversize  = d_over;
    end
  endgenerate

endmodule

module tagged_ptr_decode_chk #(
  parameter int PTR_W = 10,
  parameter int FIT_MAX_EXP = 3,
  localparam int ADDR_W = PTR_W - 1,
  localparam int EXP_W = $clog2(PTR_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [EXP_W-1:0]  size_exp,
  input logic [PTR_W-1:0]  byte_cnt,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              fits,
  input logic              oversize
);

  // R3
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (({1'b0, byte_addr} & (byte_cnt - PTR_W'(1))) == '0));

  // R5
  count_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (byte_cnt == (PTR_W'(1) << size_exp)));

  // R6
  null_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (size_exp == '0 && byte_cnt == '0 && byte_addr == '0 && !fits && !oversize));

  // R7
  class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (fits != oversize));

  // R7
  fit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fits |-> (size_exp <= EXP_W'(FIT_MAX_EXP)));

  // R4
  whole_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size_exp == EXP_W'(PTR_W - 1)) |-> (byte_addr == '0 && oversize));

endmodule

bind tagged_ptr_decode tagged_ptr_decode_chk #(
  .PTR_W(PTR_W),
  .FIT_MAX_EXP(FIT_MAX_EXP)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .valid(valid),
  .size_exp(size_exp),
  .byte_cnt(byte_cnt),
  .byte_addr(byte_addr),
  .fits(fits),
  .oversize(oversize)
);

// File: tb/test_tagged_ptr_decode.sv
module test_tagged_ptr_decode;
  localparam int PTR_W = 10;
  localparam int ADDR_W = PTR_W - 1;
  localparam int EXP_W = $clog2(PTR_W);
  localparam int FIT_MAX = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PTR_W-1:0] ptr = '0;

  logic c_valid, c_fits, c_over;
  logic [EXP_W-1:0] c_exp;
  logic [PTR_W-1:0] c_cnt;
  logic [ADDR_W-1:0] c_addr;

  logic r_valid, r_fits, r_over;
  logic [EXP_W-1:0] r_exp;
  logic [PTR_W-1:0] r_cnt;
  logic [ADDR_W-1:0] r_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tagged_ptr_decode #(.PTR_W(PTR_W), .FIT_MAX_EXP(FIT_MAX), .OUT_REG(1'b0)) i_tagged_ptr_decode (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .valid(c_valid), .size_exp(c_exp),
    .byte_cnt(c_cnt), .byte_addr(c_addr), .fits(c_fits), .oversize(c_over));

  tagged_ptr_decode #(.PTR_W(PTR_W), .FIT_MAX_EXP(FIT_MAX), .OUT_REG(1'b1)) i_tagged_ptr_decode_q (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .valid(r_valid), .size_exp(r_exp),
    .byte_cnt(r_cnt), .byte_addr(r_addr), .fits(r_fits), .oversize(r_over));

  // Reference model: {valid, exp, cnt, addr, fits, over}
  typedef struct packed {
    logic              v;
    logic [EXP_W-1:0]  e;
    logic [PTR_W-1:0]  c;
    logic [ADDR_W-1:0] a;
    logic              f;
    logic              o;
  } dec_t;

  function automatic dec_t model(input logic [PTR_W-1:0] p);
    dec_t d = '0;
    int top = -1;
    for (int i = 0; i < PTR_W; i++) if (p[i]) top = i;
    if (top >= 0) begin
      int n = PTR_W - 1 - top;
      int low = 0;
      for (int i = 0; i < top; i++) if (p[i]) low += (1 << i);
      d.v = 1'b1;
      d.e = EXP_W'(n);
      d.c = PTR_W'(1 << n);
      d.a = ADDR_W'(low << n);
      d.f = (n <= FIT_MAX);
      d.o = (n > FIT_MAX);
    end
    return d;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (ptr=%0d)", tag, act, exp, ptr);
    end
  endtask

  task automatic check_comb(input dec_t d);
    check("R6 valid", int'(c_valid), int'(d.v));
    check("R1 size_exp", int'(c_exp), int'(d.e));
    check("R2 byte_addr", int'(c_addr), int'(d.a));
    check("R5 byte_cnt", int'(c_cnt), int'(d.c));
    check("R7 fits", int'(c_fits), int'(d.f));
    check("R7 oversize", int'(c_over), int'(d.o));
    if (c_valid) check("R3 alignment", int'(c_addr) % (1 << c_exp), 0);
  endtask

  task automatic check_reg(input string tag, input dec_t d);
    check(tag, int'({r_valid, r_exp, r_cnt, r_addr, r_fits, r_over}), int'(d));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    @(negedge clk);
    ptr = PTR_W'(3);
    @(posedge clk); #1;
    check_reg("R8 reset clears registered outputs", '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    for (int p = 0; p < (1 << PTR_W); p++) begin
      @(negedge clk);
      ptr = PTR_W'(p);
      #1;
      check_comb(model(ptr));
      @(posedge clk); #1;
      check_reg("R8 registered sweep", model(PTR_W'(p)));
    end
  endtask

  task automatic t_corners;
    @(negedge clk); ptr = PTR_W'(1); #1;
    check("R4 whole-memory exp", int'(c_exp), PTR_W - 1);
    check("R4 whole-memory addr", int'(c_addr), 0);
    check("R4 whole-memory cnt", int'(c_cnt), 1 << (PTR_W - 1));
    check("R4 whole-memory oversize", int'(c_over), 1);
    @(negedge clk); ptr = '0; #1;
    check("R6 null valid", int'(c_valid), 0);
    check("R6 null outputs", int'({c_exp, c_cnt, c_addr, c_fits, c_over}), 0);
    // 8-byte boundary: 0b0001xxxxxx -> N=3 fits, 0b00001xxxxx -> N=4 oversize
    @(negedge clk); ptr = 10'b0001_101101; #1;
    check("R7 N=3 fits", int'(c_fits), 1);
    check("R2 N=3 addr", int'(c_addr), 9'b101101_000);
    @(negedge clk); ptr = 10'b00001_10110; #1;
    check("R7 N=4 oversize", int'(c_over), 1);
    check("R7 N=4 not fits", int'(c_fits), 0);
    check("R2 N=4 addr", int'(c_addr), 9'b10110_0000);
  endtask

  task automatic t_latency;
    @(negedge clk); ptr = 10'b1_000000011; #1;
    check("R8 comb same cycle", int'(c_addr), 9'b000000011);
    @(posedge clk); #1;
    check_reg("R8 registered after edge", model(10'b1_000000011));
    @(negedge clk); ptr = 10'b01_00000001; #1;
    check_reg("R8 registered holds before edge", model(10'b1_000000011));
    @(posedge clk); #1;
    check_reg("R8 registered updates at edge", model(10'b01_00000001));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_corners();
    t_latency();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule